// File: doc/BRIEF.md
# Spindle Period Comparison Speed Servo

This block regulates spindle speed as a bang-bang loop. A conditioned pulse train from a notched ring turning with the spindle is halved by a toggle stage into a square wave. The time between consecutive rising edges of that square wave is measured by counting ticks from one of three reference clock taps. The result is reduced to a single bit, "increase speed", which is meant for an external integrator that sets the motor's phase-angle trigger. Because the error carries no magnitude, the spindle settles into a limit cycle around the target speed.

A down counter is preset with the target period. A borrow past zero means the spindle is too slow. The size of the remaining count, or of the excess count, is compared against a band of one percent of the target to give an out-of-tolerance flag. That flag is ANDed with a ready input to form the disk-speed-error output. A purge flag replaces the nominal target with a shorter, overspeed target. Each result first goes into a value register and then into a status register. A small sequencer does both transfers, one selected tick after the other, once each rising edge has been seen. A start pulse or a dropped motor enable puts the status back into its "not at speed" state. If no edge arrives before the count reaches twice the target, the counter saturates and forces the status to out-of-tolerance.

Top module: `spd_servo`

## Requirements
- R1: The ring input passes through a synchronizer and a toggle stage, which starts at 0 after reset and while the motor enable is low. Only the toggle's 0-to-1 transitions, which come on every second ring pulse, start a measurement sequence.
- R2: The measured count m is the number of selected ticks strictly between the reload tick of one sequence and the latch tick of the next. The latch tick is the first selected tick after a detected edge, and the reload tick is the selected tick after that. A square-wave period of T selected ticks therefore gives m = T - 2. The increase-speed output is 1 exactly when m exceeds the target count.
- R3: The out-of-tolerance output is 1 when |m - target| exceeds target/100 (integer division), and 0 otherwise.
- R4: At each reload, the target is chosen as the overspeed count (default 180) when the purge input is 1, and as the nominal count (default 200) otherwise. The chosen target applies to the measurement that begins at that reload.
- R5: Tap select 0 counts reference tap 0 and select 1 counts tap 1. Selects 2 and 3 both count tap 2.
- R6: If the count since the last reload reaches twice the target with no edge, the counter saturates and the status is forced at once to increase-speed 1 and out-of-tolerance 1. Before that point, the status keeps its last value.
- R7: The disk-speed-error output equals out-of-tolerance AND ready.
- R8: A start pulse with the motor enabled sets the status to increase-speed 1 and out-of-tolerance 1. Later measurements then update the status normally.
- R9: While the motor enable is low, the sequencer is idle and the status reads increase-speed 1 and out-of-tolerance 1. The first edge after the enable rises (or after reset) only reloads the counter and leaves the status unchanged.
- R10: After reset, increase-speed is 1 and out-of-tolerance is 1.
- R11: The status changes only at a reload tick, on saturation, on a start pulse, or while the enable is low. In all other cycles it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_i | input | 1 | Conditioned speed-ring pulse train |
| ref_tick_i | input | 3 | One-cycle tick strobes from three reference taps |
| tap_sel_i | input | 2 | Static choice of reference tap |
| purge_i | input | 1 | Selects the overspeed target |
| start_i | input | 1 | Start-motor pulse, initializes the status |
| motor_en_i | input | 1 | Motor enable; low holds sequencer and status in reset |
| ready_i | input | 1 | Drive ready, gates the disk-speed error |
| incr_speed_o | output | 1 | One-bit speed error: 1 asks for more speed |
| oot_o | output | 1 | Speed out of tolerance |
| disk_err_o | output | 1 | Out-of-tolerance gated by ready |

## Verification
The hardest state to reach is saturation. It only comes after a long run with no ring edges, and the status must not move before the limit and must move right after it. The bench stops pulsing after a good measurement and checks the status once partway to twice the target and again past it. It then resumes pulsing to confirm that the saturated measurement is reported and that recovery follows. The first edge after enable, which must only reload, is reached by dropping the enable between measurement sweeps. The tolerance boundaries are covered by sweeping the ring period one tick at a time across both band edges, for both targets and for every tap.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LATCH = 2'd1,
        SEQ_LOAD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic incr;
        logic oot;
    } spd_flags_t;

    localparam spd_flags_t FLAGS_INIT = '{incr: 1'b1, oot: 1'b1};

endpackage

// File: rtl/spd_ring_edge.sv
module spd_ring_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic ring_i,
    output logic edge_o
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   sq;
    } ring_q_t;

    ring_q_t ring_d, ring_q;
    logic    pulse_rise;

    always_comb begin
        ring_d      = ring_q;
        ring_d.sync = {ring_q.sync[MSB-1:0], ring_i};
        ring_d.prev = ring_q.sync[MSB];
        pulse_rise  = ring_q.sync[MSB] & ~ring_q.prev;
        if (pulse_rise) begin
            ring_d.sq = ~ring_q.sq;
        end
        if (!en_i) begin
            ring_d.sq = 1'b0;
        end
        edge_o = pulse_rise & ~ring_q.sq & en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    // R1: a measurement start is never followed by another in the next cycle
    assert_edge_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> !edge_o);

endmodule

// File: rtl/spd_period_ctr.sv
module spd_period_ctr #(
    parameter int NOM_CNT   = 200,
    parameter int PURGE_CNT = 180
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic tick_i,
    input  logic reload_i,
    input  logic purge_i,
    output logic slow_o,
    output logic band_o,
    output logic stall_o
);
    localparam int MAXC = (NOM_CNT > PURGE_CNT) ? NOM_CNT : PURGE_CNT;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] NOM_C       = CW'(NOM_CNT);
    localparam logic [CW-1:0] PURGE_C     = CW'(PURGE_CNT);
    localparam logic [CW-1:0] NOM_TOL_C   = CW'(NOM_CNT / 100);
    localparam logic [CW-1:0] PURGE_TOL_C = CW'(PURGE_CNT / 100);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          brw;
        logic          tgt;
    } ctr_q_t;

    localparam ctr_q_t CTR_RST = '{cnt: NOM_C, brw: 1'b0, tgt: 1'b0};

    ctr_q_t        ctr_d, ctr_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] tol;

    always_comb begin
        limit = ctr_q.tgt ? PURGE_C : NOM_C;
        tol   = ctr_q.tgt ? PURGE_TOL_C : NOM_TOL_C;
        ctr_d = ctr_q;
        if (!en_i || reload_i) begin
            ctr_d.cnt = purge_i ? PURGE_C : NOM_C;
            ctr_d.brw = 1'b0;
            ctr_d.tgt = purge_i;
        end else if (tick_i) begin
            if (!ctr_q.brw) begin
                if (ctr_q.cnt == '0) begin
                    ctr_d.brw = 1'b1;
                    ctr_d.cnt = CW'(1);
                end else begin
                    ctr_d.cnt = ctr_q.cnt - 1'b1;
                end
            end else if (ctr_q.cnt != limit) begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
        slow_o  = ctr_q.brw;
        band_o  = ctr_q.cnt > tol;
        stall_o = ctr_q.brw && (ctr_q.cnt == limit);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctr_q <= CTR_RST;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // R6: once saturated the count holds until the next reload
    assert_saturate_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && !reload_i && en_i) |=> $stable(ctr_q.cnt));

    // R4: a reload under purge starts from the overspeed target
    assert_purge_preset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_i && purge_i && en_i) |=> (ctr_q.cnt == PURGE_C && !ctr_q.brw && ctr_q.tgt));

endmodule

// File: rtl/spd_seq.sv
module spd_seq
    import spd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       start_i,
    input  logic       tick_i,
    input  logic       edge_i,
    input  logic       slow_i,
    input  logic       band_i,
    input  logic       stall_i,
    output logic       reload_o,
    output spd_flags_t status_o
);
    typedef struct packed {
        seq_state_e st;
        logic       primed;
        spd_flags_t value;
        spd_flags_t status;
    } seq_q_t;

    localparam seq_q_t SEQ_RST = '{st: SEQ_IDLE, primed: 1'b0,
                                   value: FLAGS_INIT, status: FLAGS_INIT};

    seq_q_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        reload_o = 1'b0;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (edge_i) seq_d.st = SEQ_LATCH;
            end
            SEQ_LATCH: begin
                if (tick_i) begin
                    if (seq_q.primed) begin
                        seq_d.value.incr = slow_i;
                        seq_d.value.oot  = band_i;
                    end
                    seq_d.st = SEQ_LOAD;
                end
            end
            SEQ_LOAD: begin
                if (tick_i) begin
                    reload_o     = 1'b1;
                    seq_d.primed = 1'b1;
                    seq_d.st     = SEQ_IDLE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
        if (stall_i) begin
            seq_d.status = FLAGS_INIT;
        end
        if (reload_o && seq_q.primed) begin
            seq_d.status = seq_q.value;
        end
        if (start_i) begin
            seq_d.status = FLAGS_INIT;
        end
        if (!en_i) begin
            seq_d    = SEQ_RST;
            reload_o = 1'b0;
        end
        status_o = seq_q.status;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R11: status moves only on transfer, saturation, start or disable
    assert_status_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.status != $past(seq_q.status)) |->
            $past(reload_o || stall_i || start_i || !en_i));

    // R8: start pulse initializes the status
    assert_start_init_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && en_i) |=> (seq_q.status == FLAGS_INIT));

    // R9: disabled motor holds sequencer and status in reset
    assert_disable_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (seq_q.st == SEQ_IDLE && !seq_q.primed && seq_q.status == FLAGS_INIT));

endmodule

// File: rtl/spd_servo.sv
module spd_servo
    import spd_pkg::*;
#(
    parameter int NOM_CNT     = 200,
    parameter int PURGE_CNT   = 180,
    parameter int SYNC_STAGES = 2,
    parameter int TAP_COUNT   = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         ring_i,
    input  logic [TAP_COUNT-1:0]         ref_tick_i,
    input  logic [$clog2(TAP_COUNT)-1:0] tap_sel_i,
    input  logic                         purge_i,
    input  logic                         start_i,
    input  logic                         motor_en_i,
    input  logic                         ready_i,
    output logic                         incr_speed_o,
    output logic                         oot_o,
    output logic                         disk_err_o
);
    localparam int SELW = $clog2(TAP_COUNT);

    logic       tick;
    logic       edge_s;
    logic       reload;
    logic       slow;
    logic       band;
    logic       stall;
    spd_flags_t status;

    // R5: tap choice, out-of-range selects fall back to the last tap
    always_comb begin
        tick = ref_tick_i[TAP_COUNT-1];
        for (int i = 0; i < TAP_COUNT; i++) begin
            if (tap_sel_i == SELW'(i)) tick = ref_tick_i[i];
        end
    end

    spd_ring_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ring (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (motor_en_i),
        .ring_i (ring_i),
        .edge_o (edge_s)
    );

    spd_period_ctr #(.NOM_CNT(NOM_CNT), .PURGE_CNT(PURGE_CNT)) u_ctr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (motor_en_i),
        .tick_i   (tick),
        .reload_i (reload),
        .purge_i  (purge_i),
        .slow_o   (slow),
        .band_o   (band),
        .stall_o  (stall)
    );

    spd_seq u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (motor_en_i),
        .start_i  (start_i),
        .tick_i   (tick),
        .edge_i   (edge_s),
        .slow_i   (slow),
        .band_i   (band),
        .stall_i  (stall),
        .reload_o (reload),
        .status_o (status)
    );

    assign incr_speed_o = status.incr;
    assign oot_o        = status.oot;
    assign disk_err_o   = status.oot & ready_i;   // R7

endmodule

// File: tb/sim_spd_servo.sv
module sim_spd_servo;
    localparam int NOM   = 200;
    localparam int PURGE = 180;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring = 1'b0;
    logic [2:0] ref_tick = 3'b000;
    logic [1:0] tap_sel = 2'd0;
    logic       purge = 1'b0;
    logic       start = 1'b0;
    logic       en = 1'b0;
    logic       ready = 1'b0;
    logic       incr, oot, disk_err;

    int checks = 0;
    int fails = 0;
    int prev_t = 0;
    int prev_tgt = NOM;
    int tc = 0;
    bit done = 1'b0;

    spd_servo u0 (
        .clk_i(clk), .rst_ni(rst_n), .ring_i(ring), .ref_tick_i(ref_tick),
        .tap_sel_i(tap_sel), .purge_i(purge), .start_i(start),
        .motor_en_i(en), .ready_i(ready), .incr_speed_o(incr),
        .oot_o(oot), .disk_err_o(disk_err)
    );

    always #4 clk = ~clk;

    // tap 0 every 2 clocks, tap 1 every 4, tap 2 every 8
    initial begin
        forever begin
            @(negedge clk);
            tc = tc + 1;
            ref_tick = {(tc % 8) == 0, (tc % 4) == 0, (tc % 2) == 0};
        end
    end

    function automatic int tick_len();
        return (tap_sel == 2'd0) ? 2 : (tap_sel == 2'd1) ? 4 : 8;
    endfunction

    task automatic wait_ticks(input int n);
        repeat (n * tick_len()) @(negedge clk);
    endtask

    task automatic chk(input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic void expect_of(input int m, input int tgt,
                                      output int e_inc, output int e_oot);
        int tol = tgt / 100;
        if (m >= 2 * tgt) begin
            e_inc = 1; e_oot = 1;
        end else if (m > tgt) begin
            e_inc = 1; e_oot = (m - tgt > tol) ? 1 : 0;
        end else begin
            e_inc = 0; e_oot = (tgt - m > tol) ? 1 : 0;
        end
    endfunction

    // one square-wave period of t ticks: rising pulse, then falling pulse
    // mode 0: no check, 1: check previous period, 2: expect unchanged init
    task automatic period(input int t, input int mode, input string tag);
        int a = t / 2;
        int ei, eo;
        ring = 1'b1; wait_ticks(1); ring = 1'b0; wait_ticks(4);
        if (mode == 1) begin
            expect_of(prev_t - 2, prev_tgt, ei, eo);
            chk({tag, " increase-speed"}, int'(incr), ei);
            chk({tag, " out-of-tolerance"}, int'(oot), eo);
            chk({tag, " R7 disk error"}, int'(disk_err), eo & int'(ready));
        end else if (mode == 2) begin
            chk({tag, " incr kept"}, int'(incr), 1);
            chk({tag, " oot kept"}, int'(oot), 1);
        end
        wait_ticks(a - 5);
        ring = 1'b1; wait_ticks(1); ring = 1'b0; wait_ticks(t - a - 1);
        prev_t = t;
        prev_tgt = purge ? PURGE : NOM;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        ready = 1'b1;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk("R10 reset incr", int'(incr), 1);
        chk("R10 reset oot", int'(oot), 1);
        chk("R7 reset disk error", int'(disk_err), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        en = 1'b1;

        // R9: first edge only reloads
        period(202, 2, "R9 first edge after reset");

        // R1 R2 R3: nominal sweep across both band edges
        for (int t = 190; t <= 214; t++) begin
            ready = t[0];
            period(t, 1, "R1 R2 R3 nominal sweep");
        end
        ready = 1'b1;

        // R4: overspeed target during purge
        purge = 1'b1;
        for (int t = 172; t <= 194; t++) begin
            period(t, 1, "R4 purge sweep");
        end
        purge = 1'b0;
        period(202, 1, "R4 back to nominal");
        period(202, 1, "R4 nominal restored");

        // R5: tap selection
        for (int s = 1; s <= 3; s++) begin
            tap_sel = 2'(s);
            period(195, 0, "R5 tap switch");
            period(202, 1, "R5 tap sweep");
            period(210, 1, "R5 tap sweep");
            period(202, 1, "R5 tap sweep");
            period(202, 1, "R5 tap sweep");
        end
        tap_sel = 2'd0;
        period(202, 0, "R5 tap back");
        period(200, 1, "R5 tap 0 again");

        // R8: start pulse initializes status (adds one tick to the period)
        start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
        chk("R8 start incr", int'(incr), 1);
        chk("R8 start oot", int'(oot), 1);
        prev_t = prev_t + 1;
        period(202, 1, "R8 after start");

        // R6 R11: withheld edges
        period(202, 1, "R6 before stall");
        wait_ticks(150);
        chk("R6 R11 no early saturation incr", int'(incr), 0);
        chk("R6 R11 no early saturation oot", int'(oot), 0);
        wait_ticks(100);
        chk("R6 saturated incr", int'(incr), 1);
        chk("R6 saturated oot", int'(oot), 1);
        chk("R6 R7 saturated disk error", int'(disk_err), 1);
        prev_t = 1000;
        period(202, 1, "R6 saturated measurement");
        period(202, 1, "R6 recovery");
        period(202, 1, "R6 recovered");
        chk("R6 recovered incr", int'(incr), 0);

        // R9: motor enable drop
        en = 1'b0;
        wait_ticks(4);
        chk("R9 disabled incr", int'(incr), 1);
        chk("R9 disabled oot", int'(oot), 1);
        en = 1'b1;
        period(202, 2, "R9 first edge after enable");
        period(202, 1, "R9 after enable");
        period(190, 1, "R9 fast after enable");
        period(202, 1, "R2 R3 slow side");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule